// File: doc/BRIEF.md
# Complex Pulse Peak Detector

This block sits after a matched filter and looks for pulse peaks in its complex output stream. Each valid sample has both components cut down to a narrower signed width. The block then forms the sample's power as the sum of the two squares. It takes no square root, because only the relative size of the values matters for finding a peak.

Power values go into a sliding window of the most recent valid samples. The sample in the middle of the window is declared a peak when it is at least as large as every other entry and lies strictly above a programmable threshold. A detection is a one-cycle strobe. The power of the judged centre sample comes out beside it.

The multipliers have one register in front of them and two behind them. The two square paths are matched in delay, so they reach the adder in the same cycle. The peak comparison is enclosed between the window registers and the output registers.

Top module: `pulse_peak_finder`

## Requirements
- R1: Each component is reduced before squaring by keeping its upper RED_W bits (18 by default), which is an arithmetic right shift by IN_W-RED_W (6 by default) that rounds toward minus infinity.
- R2: The power is the unsigned 2*RED_W-bit value re*re + im*im of the reduced components, with no root taken.
- R3: For an input accepted at clock edge k, the judgement made for the window that this sample completes appears on `detect` and `peakPower` at edge k+5.
- R4: Cycles with `inValid` low do not enter the window and produce no judgement.
- R5: `detect` pulses when the centre entry (the sixth newest of the 11) is greater than or equal to each of the other ten entries and strictly greater than `threshold`. Equal neighbours do not block a detection.
- R6: A centre power equal to `threshold` is not a detection.
- R7: After reset, no judgement is made until 11 valid samples have been accepted. Reset empties the window and clears `detect` and `peakPower`.
- R8: At every judgement `peakPower` takes the centre entry's power, whether or not a detection occurs. Between judgements it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Qualifies inRe and inIm |
| inRe | input | IN_W | Signed real part of the filter output |
| inIm | input | IN_W | Signed imaginary part of the filter output |
| threshold | input | 2*RED_W | Unsigned power level a peak must exceed |
| detect | output | 1 | One-cycle strobe marking a peak at the window centre |
| peakPower | output | 2*RED_W | Power of the most recently judged centre sample |

## Verification
The assertions assume that `threshold` is steady during the cycle in which a judgement is formed. They also assume that reset is synchronous and releases at a clock edge. The bench changes the threshold only after at least six idle cycles, when no judgement is still in flight. It applies reset only through its reset task. Random stimulus mixes gaps in `inValid` with full-scale and small inputs. Directed runs place equal peaks, a centre equal to the threshold, and a reset in the middle of a stream.

// File: rtl/ppd_pkg.sv
package ppd_pkg;
  typedef struct packed {
    logic shiftEn;  // a new power value enters the window at the next edge
    logic judgeEn;  // the window was just filled and updated; judge it at the next edge
  } ppd_ctrl_t;
endpackage

// File: rtl/ppd_ctrl.sv
module ppd_ctrl
  import ppd_pkg::*;
#(
  parameter int WIN = 11,
  parameter int PIPE = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  output ppd_ctrl_t ctl
);
  localparam int CNT_W = $clog2(WIN + 1);

  logic [PIPE-1:0]  validPipe;
  logic [CNT_W-1:0] fillCnt;
  logic             judgeQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      validPipe <= '0;
      fillCnt   <= '0;
      judgeQ    <= 1'b0;
    end else begin
      validPipe <= {validPipe[PIPE-2:0], inValid};
      judgeQ    <= validPipe[PIPE-1] && (fillCnt >= CNT_W'(WIN - 1));
      if (validPipe[PIPE-1] && (fillCnt != CNT_W'(WIN)))
        fillCnt <= fillCnt + 1'b1;
    end
  end

  always_comb begin
    ctl.shiftEn = validPipe[PIPE-1];
    ctl.judgeEn = judgeQ;
  end
endmodule

// File: rtl/ppd_datapath.sv
module ppd_datapath
  import ppd_pkg::*;
#(
  parameter int IN_W  = 24,
  parameter int RED_W = 18,
  parameter int WIN   = 11
) (
  input  logic                  clk,
  input  logic                  rst,
  input  ppd_ctrl_t             ctl,
  input  logic [IN_W-1:0]       inRe,
  input  logic [IN_W-1:0]       inIm,
  input  logic [2*RED_W-1:0]    threshold,
  output logic                  detect,
  output logic [2*RED_W-1:0]    peakPower
);
  localparam int PWR_W = 2 * RED_W;
  localparam int CEN   = WIN / 2;

  logic signed [RED_W-1:0] redRe, redIm, sRe, sIm;
  logic signed [PWR_W-1:0] p1Re, p1Im, p2Re, p2Im;
  logic [PWR_W-1:0]        pwr;
  logic [PWR_W-1:0]        win [WIN];
  logic [WIN-1:0]          geVec;
  logic                    aboveThr;

  // precision reduction: keep the upper bits
  assign redRe = inRe[IN_W-1 -: RED_W];
  assign redIm = inIm[IN_W-1 -: RED_W];

  // one register before the multipliers, two after, then the adder register
  always_ff @(posedge clk) begin
    if (rst) begin
      sRe <= '0; sIm <= '0;
      p1Re <= '0; p1Im <= '0;
      p2Re <= '0; p2Im <= '0;
      pwr <= '0;
    end else begin
      sRe  <= redRe;
      sIm  <= redIm;
      p1Re <= PWR_W'(sRe) * PWR_W'(sRe);
      p1Im <= PWR_W'(sIm) * PWR_W'(sIm);
      p2Re <= p1Re;
      p2Im <= p1Im;
      pwr  <= $unsigned(p2Re) + $unsigned(p2Im);
    end
  end

  // tapped delay window, entry 0 newest
  for (genvar i = 0; i < WIN; i++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst)              win[i] <= '0;
      else if (ctl.shiftEn) win[i] <= (i == 0) ? pwr : win[(i == 0) ? 0 : i - 1];
    end
  end

  // centre versus every other tap
  for (genvar i = 0; i < WIN; i++) begin : g_cmp
    if (i == CEN) begin : g_self
      assign geVec[i] = 1'b1;
    end else begin : g_other
      assign geVec[i] = (win[CEN] >= win[i]);
    end
  end
  assign aboveThr = (win[CEN] > threshold);

  always_ff @(posedge clk) begin
    if (rst) begin
      detect    <= 1'b0;
      peakPower <= '0;
    end else begin
      detect <= ctl.judgeEn && (&geVec) && aboveThr;
      if (ctl.judgeEn) peakPower <= win[CEN];
    end
  end
endmodule

// File: rtl/pulse_peak_finder.sv
module pulse_peak_finder
  import ppd_pkg::*;
#(
  parameter int IN_W  = 24,
  parameter int RED_W = 18,
  parameter int WIN   = 11
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic [IN_W-1:0]      inRe,
  input  logic [IN_W-1:0]      inIm,
  input  logic [2*RED_W-1:0]   threshold,
  output logic                 detect,
  output logic [2*RED_W-1:0]   peakPower
);
  ppd_ctrl_t ctl;

  ppd_ctrl #(.WIN(WIN), .PIPE(4)) i_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .ctl(ctl)
  );

  ppd_datapath #(.IN_W(IN_W), .RED_W(RED_W), .WIN(WIN)) i_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .inRe(inRe), .inIm(inIm),
    .threshold(threshold), .detect(detect), .peakPower(peakPower)
  );
endmodule

// File: rtl/ppd_checker.sv
module ppd_checker #(
  parameter int WIN   = 11,
  parameter int PWR_W = 36
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic [PWR_W-1:0] threshold,
  input logic             detect,
  input logic [PWR_W-1:0] peakPower
);
  localparam int CNT_W = $clog2(WIN + 1);
  logic [CNT_W-1:0] seenCnt;

  always_ff @(posedge clk) begin
    if (rst) seenCnt <= '0;
    else if (inValid && seenCnt != CNT_W'(WIN)) seenCnt <= seenCnt + 1'b1;
  end

  // R5, R6: a detection always lies strictly above the threshold used
  assert_above_threshold_R6: assert property (@(posedge clk) disable iff (rst)
    detect |-> (peakPower > $past(threshold)));

  // R3, R4: a detection traces back to a valid input five edges earlier
  assert_valid_origin_R3: assert property (@(posedge clk) disable iff (rst)
    detect |-> $past(inValid, 6));

  // R7: no detection before the window has been filled
  assert_filled_R7: assert property (@(posedge clk) disable iff (rst)
    detect |-> (seenCnt == CNT_W'(WIN)));

  // R8: peak value holds when no judgement was due
  assert_peak_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(inValid, 6)) |-> $stable(peakPower));

  // R4: no detection in a cycle whose originating slot was idle
  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(inValid, 6) |-> !detect);
endmodule

bind pulse_peak_finder ppd_checker #(.WIN(WIN), .PWR_W(2 * RED_W)) i_ppd_checker (
  .clk(clk), .rst(rst), .inValid(inValid), .threshold(threshold),
  .detect(detect), .peakPower(peakPower)
);

// File: tb/test_pulse_peak_finder.sv
module test_pulse_peak_finder;
  localparam int IN_W = 24;
  localparam int RED_W = 18;
  localparam int PWR_W = 36;
  localparam int WIN = 11;
  localparam int LAT = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [IN_W-1:0] inRe = '0, inIm = '0;
  logic [PWR_W-1:0] threshold = '0;
  logic detect;
  logic [PWR_W-1:0] peakPower;

  always #2 clk = ~clk;  // 250 MHz

  pulse_peak_finder #(.IN_W(IN_W), .RED_W(RED_W), .WIN(WIN)) i_pulse_peak_finder (
    .clk(clk), .rst(rst), .inValid(inValid), .inRe(inRe), .inIm(inIm),
    .threshold(threshold), .detect(detect), .peakPower(peakPower)
  );

  int checks = 0, fails = 0, cyc = 0, filled = 0;
  longint hist [WIN];
  bit     slotJudge [16];
  bit     slotDet [16];
  longint slotPeak [16];
  string  tag = "R7";

  function automatic longint power(logic [IN_W-1:0] re, logic [IN_W-1:0] im);
    longint r, i;
    r = longint'($signed(re)) >>> (IN_W - RED_W);  // R1
    i = longint'($signed(im)) >>> (IN_W - RED_W);
    return r * r + i * i;                           // R2
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic modelClear();
    filled = 0;
    for (int i = 0; i < WIN; i++) hist[i] = 0;
    for (int i = 0; i < 16; i++) begin slotJudge[i] = 0; slotDet[i] = 0; end
  endtask

  // called at a negedge: drive, clock, model, check
  task automatic tick(bit v, logic [IN_W-1:0] re, logic [IN_W-1:0] im);
    int s;
    bit ge;
    inValid = v; inRe = re; inIm = im;
    @(posedge clk);
    cyc++;
    if (rst) modelClear();
    else if (v) begin
      for (int i = WIN - 1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = power(re, im);
      if (filled < WIN) filled++;
      if (filled == WIN) begin
        s = (cyc + LAT) % 16;
        ge = 1;
        for (int i = 0; i < WIN; i++) if (hist[WIN/2] < hist[i]) ge = 0;
        slotJudge[s] = 1;
        slotPeak[s]  = hist[WIN/2];
        slotDet[s]   = ge && (hist[WIN/2] > longint'(threshold));
      end
    end
    @(negedge clk);
    s = cyc % 16;
    chk(detect == (slotJudge[s] && slotDet[s]), {tag, " R3 R5 detect"},
        longint'(detect), longint'(slotJudge[s] && slotDet[s]));
    if (slotJudge[s])
      chk(longint'(peakPower) == slotPeak[s], {tag, " R1 R2 R8 peak"},
          longint'(peakPower), slotPeak[s]);
    slotJudge[s] = 0;
    slotDet[s] = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(1'b0, '0, '0);
  endtask

  task automatic doReset();
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
  endtask

  function automatic logic [IN_W-1:0] amp(int a);
    return IN_W'(a) << (IN_W - RED_W);
  endfunction

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog R7: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    modelClear();
    @(negedge clk);
    doReset();
    // reset state (R7)
    chk(detect == 1'b0, "R7 reset detect", longint'(detect), 0);
    chk(peakPower == '0, "R7 reset peak", longint'(peakPower), 0);

    // single spike, fill gating: first 10 samples cannot judge (R7)
    tag = "R7"; threshold = 36'd100;
    for (int i = 0; i < 20; i++) tick(1'b1, (i == 8) ? amp(50) : amp(1), amp(-1));
    idle(8);

    // equal neighbours both detect (R5)
    tag = "R5";
    for (int i = 0; i < 20; i++) tick(1'b1, (i == 9 || i == 10) ? amp(-300) : amp(2), amp(3));
    idle(8);

    // centre equal to threshold: no detection (R6); reduced 30,40 -> 2500
    tag = "R6"; threshold = 36'd2500;
    for (int i = 0; i < 20; i++) tick(1'b1, (i == 12) ? amp(30) : amp(1), (i == 12) ? amp(40) : '0);
    idle(8);
    threshold = 36'd2499;
    for (int i = 0; i < 20; i++) tick(1'b1, (i == 12) ? amp(30) : amp(1), (i == 12) ? amp(40) : '0);
    idle(8);

    // full scale and low bits dropped (R1, R2)
    tag = "R1 R2"; threshold = 36'd1000;
    for (int i = 0; i < 20; i++)
      tick(1'b1, (i == 7) ? {1'b1, {(IN_W-1){1'b0}}} : 24'h00003F,
                 (i == 7) ? {1'b1, {(IN_W-1){1'b0}}} : 24'hFFFFC1);
    idle(8);

    // random with valid gaps (R4)
    tag = "R4"; threshold = 36'd1 << 30;
    for (int i = 0; i < 3000; i++)
      tick(($urandom % 4) != 0, IN_W'($urandom), IN_W'($urandom));
    idle(8);

    // reset in mid-stream restarts filling (R7)
    tag = "R7"; threshold = 36'd10;
    for (int i = 0; i < 8; i++) tick(1'b1, amp(100), amp(0));
    doReset();
    chk(peakPower == '0, "R7 mid reset peak", longint'(peakPower), 0);
    for (int i = 0; i < 16; i++) tick(1'b1, (i == 5) ? amp(90) : amp(1), amp(0));
    idle(8);

    // random small amplitudes, dense valid (R5, R8)
    tag = "R5 R8"; threshold = 36'd20;
    for (int i = 0; i < 2000; i++)
      tick(($urandom % 8) != 0, amp(int'($urandom % 9) - 4), amp(int'($urandom % 9) - 4));
    idle(8);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule